// File: doc/BRIEF.md
# Conversion Result Register with Split-Read Lock

This block stores the latest conversion code from a converter sequencer and presents it to a byte-wide bus as a low byte and a high byte. A control input chooses whether the code is packed toward the bottom of the 16-bit pair (right aligned) or toward the top (left aligned). In left alignment the high byte alone carries the eight most significant bits, so software that needs only 8-bit precision reads one byte.

A two-byte read is made coherent by a lock. Reading the low byte freezes both bytes. Reading the high byte releases them. Any result that completes while the bytes are frozen is thrown away, but its completion is still reported. A completion flag is raised on every result, cleared by a write of one or by an interrupt acknowledge, and gated with an enable to form the interrupt request.

Results arrive on a valid/ready stream. `res_ready` is held high at all times, so a result is taken in every cycle where `res_valid` is high and is never back-pressured. Whether it is stored or dropped depends only on the lock. The sequencer needs no retry path.

Top module: `adcres_top`

## Requirements
- R1: With `align_left` low, `data_hi[1:0]` shows code bits 9:8, `data_hi[7:2]` reads zero, and `data_lo` shows code bits 7:0.
- R2: With `align_left` high, `data_hi` shows code bits 9:2, `data_lo[7:6]` shows code bits 1:0, and `data_lo[5:0]` reads zero.
- R3: A change of `align_left` changes both bytes in the same cycle, with no clock edge, and uses the stored code.
- R4: While unlocked, a cycle with `res_valid` high stores `res_code`, and the new bytes appear after that clock edge.
- R5: A cycle with `rd_lo` high and `rd_hi` low locks the register. While it is locked, arriving results leave both bytes unchanged.
- R6: A cycle with `rd_hi` high unlocks the register, including when `rd_lo` is high in the same cycle. A later result is stored.
- R7: A result in the same cycle as a low-byte-only read is dropped. A result in the same cycle as a high-byte read is stored, even while the register is locked.
- R8: Every cycle with `res_valid` high sets `done_flag`, including for dropped results. `irq_req` equals `done_flag` AND `irq_en`.
- R9: `flag_clr` or `irq_ack` clears `done_flag`. A new result in the same cycle wins, and the flag stays set.
- R10: `res_ready` is high in every cycle.
- R11: After reset both bytes read zero, `done_flag` is low, and the register is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Always high; results are never back-pressured |
| res_code | input | 10 | Conversion code |
| align_left | input | 1 | 1 = left aligned, 0 = right aligned |
| rd_lo | input | 1 | Low byte read strobe |
| rd_hi | input | 1 | High byte read strobe |
| flag_clr | input | 1 | Write-one clear of the completion flag |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| irq_en | input | 1 | Interrupt enable |
| data_lo | output | 8 | Low result byte |
| data_hi | output | 8 | High result byte |
| done_flag | output | 1 | Completion flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle: a result arriving, and a byte read that changes the lock. The bench asserts `res_valid` with `rd_lo` alone and checks that the bytes still show the previous code while the flag rises. It then asserts `res_valid` with `rd_hi` while locked and checks that the new code shows after the edge. A second collision, a result arriving with a flag clear, is judged by the flag staying set.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_e;
endpackage

// File: rtl/adcres_lock.sv
module adcres_lock
  import adcres_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic accept,
  output logic lock_held
);
  lock_e state_q, state_d;

  // a high-byte read ends the pair; a low-byte-only read opens it
  always_comb begin
    state_d = state_q;
    if (rd_hi)      state_d = LK_OPEN;
    else if (rd_lo) state_d = LK_HELD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_OPEN;
    else        state_q <= state_d;
  end

  // write lands after the bus has seen this cycle's bytes
  assign accept    = res_valid && (rd_hi || (state_q == LK_OPEN && !rd_lo));
  assign lock_held = (state_q == LK_HELD);
endmodule

// File: rtl/adcres_store.sv
module adcres_store #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (accept) code_q <= code_in;
  end
endmodule

// File: rtl/adcres_align.sv
module adcres_align #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              align_left,
  input  logic [CODE_W-1:0] code,
  output logic [BYTE_W-1:0] byte_lo,
  output logic [BYTE_W-1:0] byte_hi
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - CODE_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W == 0) begin : g_full
      assign pair = code;
    end else begin : g_pad
      assign pair = align_left ? {code, {PAD_W{1'b0}}}
                               : {{PAD_W{1'b0}}, code};
    end
  endgenerate

  assign byte_hi = pair[PAIR_W-1:BYTE_W];
  assign byte_lo = pair[BYTE_W-1:0];
endmodule

// File: rtl/adcres_flag.sv
module adcres_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_q,
  output logic req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign req_o = flag_q & en_i;
endmodule

// File: rtl/adcres_top.sv
module adcres_top #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CODE_W-1:0] res_code,
  input  logic              align_left,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              flag_clr,
  input  logic              irq_ack,
  input  logic              irq_en,
  output logic [BYTE_W-1:0] data_lo,
  output logic [BYTE_W-1:0] data_hi,
  output logic              done_flag,
  output logic              irq_req
);
  logic              accept;
  logic              lock_held;
  logic [CODE_W-1:0] code_q;

  assign res_ready = 1'b1;

  adcres_lock lock_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
    .rd_lo(rd_lo), .rd_hi(rd_hi),
    .accept(accept), .lock_held(lock_held)
  );

  adcres_store #(.CODE_W(CODE_W)) store_i (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .code_in(res_code), .code_q(code_q)
  );

  adcres_align #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) align_i (
    .align_left(align_left), .code(code_q),
    .byte_lo(data_lo), .byte_hi(data_hi)
  );

  adcres_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set_i(res_valid),
    .clr_i(flag_clr | irq_ack), .en_i(irq_en),
    .flag_q(done_flag), .req_o(irq_req)
  );
endmodule

// File: rtl/adcres_chk.sv
module adcres_chk #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [CODE_W-1:0] res_code,
  input logic              align_left,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              flag_clr,
  input logic              irq_ack,
  input logic [BYTE_W-1:0] data_lo,
  input logic [BYTE_W-1:0] data_hi,
  input logic              done_flag,
  input logic              lock_held,
  input logic [CODE_W-1:0] code_q
);
  localparam int PAD_W = 2 * BYTE_W - CODE_W;

  // R1
  right_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !align_left |-> data_hi[BYTE_W-1:CODE_W-BYTE_W] == '0);

  // R2
  left_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_left |-> data_lo[PAD_W-1:0] == '0);

  // R4
  open_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !lock_held && !rd_lo) |=> code_q == $past(res_code));

  // R5
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && !rd_hi) |=> $stable(code_q));

  // R5
  lo_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> lock_held);

  // R6
  hi_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !lock_held);

  // R7
  lo_collision_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && rd_lo && !rd_hi) |=> $stable(code_q));

  // R8
  flag_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> done_flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && (flag_clr || irq_ack)) |=> !done_flag);
endmodule

bind adcres_top adcres_chk #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_code(res_code),
  .align_left(align_left), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .flag_clr(flag_clr), .irq_ack(irq_ack),
  .data_lo(data_lo), .data_hi(data_hi), .done_flag(done_flag),
  .lock_held(lock_held), .code_q(code_q)
);

// File: tb/adcres_top_tb_top.sv
`timescale 1ns/1ps
module adcres_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [9:0] res_code = '0;
  logic       align_left = 1'b0;
  logic       rd_lo = 1'b0, rd_hi = 1'b0;
  logic       flag_clr = 1'b0, irq_ack = 1'b0, irq_en = 1'b0;
  logic [7:0] data_lo, data_hi;
  logic       done_flag, irq_req;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adcres_top dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .align_left(align_left), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .irq_en(irq_en),
    .data_lo(data_lo), .data_hi(data_hi), .done_flag(done_flag), .irq_req(irq_req)
  );

  // {align, code, exp_hi, exp_lo}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 10'h3FF, 8'h03, 8'hFF}, {1'b1, 10'h3FF, 8'hFF, 8'hC0},
    {1'b0, 10'h2A5, 8'h02, 8'hA5}, {1'b1, 10'h2A5, 8'hA9, 8'h40},
    {1'b0, 10'h155, 8'h01, 8'h55}, {1'b1, 10'h155, 8'h55, 8'h40},
    {1'b0, 10'h001, 8'h00, 8'h01}, {1'b1, 10'h001, 8'h00, 8'h40},
    {1'b0, 10'h200, 8'h02, 8'h00}, {1'b1, 10'h200, 8'h80, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [9:0] c);
    res_code = c; res_valid = 1'b1;
    step();
    res_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 lo", {8'h0, data_lo}, 16'h0);
    chk("R11 hi", {8'h0, data_hi}, 16'h0);
    chk("R11 flag", {15'h0, done_flag}, 16'h0);
    rst_n = 1'b1;
    step();
    // R11 unlocked: a result is stored
    push(10'h0AB);
    chk("R11 unlocked", {data_hi, data_lo}, 16'h00AB);
    chk("R10 ready", {15'h0, res_ready}, 16'h1);

    // R1 R2 R4 table walk
    foreach (VEC[i]) begin
      align_left = VEC[i][26];
      push(VEC[i][25:16]);
      chk(VEC[i][26] ? "R2 R4 hi" : "R1 R4 hi", {8'h0, data_hi}, {8'h0, VEC[i][15:8]});
      chk(VEC[i][26] ? "R2 R4 lo" : "R1 R4 lo", {8'h0, data_lo}, {8'h0, VEC[i][7:0]});
    end

    // R3 immediate alignment change on stored 10'h200
    align_left = 1'b0; #1;
    chk("R3 right", {data_hi, data_lo}, 16'h0200);
    align_left = 1'b1; #1;
    chk("R3 left", {data_hi, data_lo}, 16'h8000);
    align_left = 1'b0;
    step();

    // R5 lock then drop
    push(10'h123);
    rd_lo = 1'b1; step(); rd_lo = 1'b0;
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    push(10'h3C3);
    chk("R5 held", {data_hi, data_lo}, 16'h0123);
    chk("R8 flag on dropped", {15'h0, done_flag}, 16'h1);
    align_left = 1'b1; #1;
    chk("R3 while held", {data_hi, data_lo}, 16'h48C0);
    align_left = 1'b0;
    // R6 unlock
    rd_hi = 1'b1; step(); rd_hi = 1'b0;
    push(10'h0F0);
    chk("R6 stored", {data_hi, data_lo}, 16'h00F0);

    // R7 collision with low read: dropped
    res_code = 10'h111; res_valid = 1'b1; rd_lo = 1'b1;
    step();
    res_valid = 1'b0; rd_lo = 1'b0;
    chk("R7 lo collide", {data_hi, data_lo}, 16'h00F0);
    // R7 collision with high read while held: stored
    res_code = 10'h222; res_valid = 1'b1; rd_hi = 1'b1;
    step();
    res_valid = 1'b0; rd_hi = 1'b0;
    chk("R7 hi collide", {data_hi, data_lo}, 16'h0222);
    // R6 both strobes at once leave it open
    rd_lo = 1'b1; rd_hi = 1'b1; step(); rd_lo = 1'b0; rd_hi = 1'b0;
    push(10'h333);
    chk("R6 both strobes", {data_hi, data_lo}, 16'h0333);

    // R8 R9 flag and request
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R9 w1c", {15'h0, done_flag}, 16'h0);
    irq_en = 1'b1;
    push(10'h001);
    chk("R8 irq", {15'h0, irq_req}, 16'h1);
    irq_en = 1'b0; #1;
    chk("R8 irq gated", {15'h0, irq_req}, 16'h0);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R9 ack", {15'h0, done_flag}, 16'h0);
    res_valid = 1'b1; flag_clr = 1'b1; irq_ack = 1'b1;
    step();
    res_valid = 1'b0; flag_clr = 1'b0; irq_ack = 1'b0;
    chk("R9 set wins", {15'h0, done_flag}, 16'h1);
    chk("R10 ready end", {15'h0, res_ready}, 16'h1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule